// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block sequences the fetch status of every hardware thread in a multithreaded front end. Each thread owns a status register and four sticky stall flags, one per downstream stage. Every cycle the block folds the stage block and unblock pulses, the squash requests from commit and decode, the reorder-buffer "still squashing" flag, a global context-switch stall, a fetch issue event, an instruction-cache response and a cache retry event into one new status per thread. PC arithmetic, decode and line storage live elsewhere. This block only moves status codes and stall flags.

Status encoding (4 bits): Running=0, Idle=1, Squashing=2, Blocked=3, TrapPending=4, QuiescePending=5, WaitResponse=6, WaitRetry=7, AccessDone=8. Idle, TrapPending and QuiescePending are encoded for the neighbours that decode the field. No transition of this block enters them.

The transitions are evaluated in this order:
1. The signal update. Commit squash comes first, then ROB squashing, then decode squash, then stall, then recovery from Blocked or Squashing to Running.
2. The cache response. A matching response takes WaitResponse to AccessDone, or to Blocked when the thread is stalled.
3. The retry grant. It takes WaitRetry to WaitResponse.
4. The fetch issue. It takes Running or AccessDone to WaitResponse when the cache accepts it, and to WaitRetry when the cache refuses it.

All threads share one retry slot. That slot, and the cache-blocked flag that comes with it, are outputs of the block.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset, every thread reads Running (0), `retry_pending` and `cache_blocked` are 0, and all stall flags are clear.
- R2: The stall flags are sticky. Bit s of `stage_block[t]` sets flag s of thread t, and the same bit of `stage_unblock[t]` clears it. The stage bits are 0 decode, 1 rename, 2 execute, 3 commit. While any flag is set, the thread goes to Blocked (3). When an unblock clears the last flag, a Blocked thread returns to Running at that same edge. Raising an unblock on a clear flag, or raising block and unblock together, is illegal.
- R3: When `ctx_stall` is high, every thread that is not in WaitResponse or WaitRetry goes to Blocked, unless a squash from R4, R5 or R6 applies to it.
- R4: `commit_squash[t]` has the highest priority. It forces thread t to Squashing (2), drops its outstanding cache request, and empties the retry slot if thread t owns it. A commit squash of another thread leaves the slot untouched.
- R5: `rob_squashing[t]` without a commit squash forces Squashing, with the same drops as R4.
- R6: `decode_squash[t]` forces Squashing, with the same drops, only when the thread is not already in Squashing. A thread already in Squashing treats the decode squash as absent.
- R7: A thread in WaitResponse (6) or WaitRetry (7) keeps its status under any stall.
- R8: A thread in Blocked or Squashing that sees no squash and no stall becomes Running on the next edge.
- R9: A fetch issue (`issue_valid`, `issue_tid`, `issue_id`) counts only when `cache_blocked` is 0 and the thread is in Running or AccessDone. It is ignored in every other case. If `issue_accept` is 1, the thread goes to WaitResponse and `issue_id` becomes its outstanding ID. If `issue_accept` is 0, the thread goes to WaitRetry, the slot records the thread and the ID, and `cache_blocked` rises.
- R10: A response for thread t completes only when the thread is in WaitResponse after step 1 and `resp_id` equals the outstanding ID. A completing response moves the thread to AccessDone (8), or to Blocked if the thread is stalled. Any other response leaves the status unchanged and pulses `resp_discard` one cycle later.
- R11: A retry event with `retry_resend_ok` moves the slot owner to WaitResponse, with the slot's ID as its outstanding ID, and empties the slot and clears `cache_blocked`. A retry event without `retry_resend_ok` changes nothing.
- R12: A retry event that finds the slot empty, including a slot emptied by a squash in the same cycle, only clears `cache_blocked`.
- R13: While the slot is occupied, its owner is in WaitRetry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_block | input | NUM_THREADS x 4 | Per-thread, per-stage block pulses |
| stage_unblock | input | NUM_THREADS x 4 | Per-thread, per-stage unblock pulses |
| ctx_stall | input | 1 | Context-switch stall for all threads |
| commit_squash | input | NUM_THREADS | Commit squash per thread |
| rob_squashing | input | NUM_THREADS | ROB still squashing, per thread |
| decode_squash | input | NUM_THREADS | Decode squash per thread |
| issue_valid | input | 1 | Fetch request issued this cycle |
| issue_tid | input | TID_W | Thread of the issued request |
| issue_id | input | ID_W | ID of the issued request |
| issue_accept | input | 1 | 1 when the cache took the request, 0 when it refused |
| resp_valid | input | 1 | Cache response event |
| resp_tid | input | TID_W | Thread tag of the response |
| resp_id | input | ID_W | Request ID of the response |
| retry_valid | input | 1 | Cache retry event |
| retry_resend_ok | input | 1 | The resend on this retry succeeded |
| thread_status | output | NUM_THREADS x 4 | Status code per thread |
| retry_pending | output | 1 | The retry slot is occupied |
| retry_tid | output | TID_W | Owner of the retry slot |
| cache_blocked | output | 1 | The cache refused a request and no retry has cleared it |
| resp_discard | output | 1 | A response was dropped in the previous cycle |

## Verification
Two collisions need the closest check: a squash landing in the same cycle as the cache response it makes stale, and a squash landing in the same cycle as a retry event for the slot it empties. The bench raises the squash together with the matching response, and together with a successful-resend retry. It expects the response to be discarded, the thread to end in Squashing, the slot to be empty, and the cache-blocked flag to be cleared. A sweep over the three starting states and all sixteen combinations of commit squash, ROB squashing, decode squash and stall checks the update priority against an arithmetic model of R3 to R8.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    typedef enum logic [3:0] {
        FS_RUN        = 4'd0,
        FS_IDLE       = 4'd1,
        FS_SQUASH     = 4'd2,
        FS_BLOCKED    = 4'd3,
        FS_TRAP       = 4'd4,
        FS_QUIESCE    = 4'd5,
        FS_WAIT_RESP  = 4'd6,
        FS_WAIT_RETRY = 4'd7,
        FS_ACC_DONE   = 4'd8
    } fstat_e;

    localparam int STAGES  = 4;
    localparam int STG_DEC = 0;
    localparam int STG_REN = 1;
    localparam int STG_EXE = 2;
    localparam int STG_CMT = 3;
endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags import fsc_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] blk,
    input  logic [STAGES-1:0] unblk,
    output logic [STAGES-1:0] flags_q,
    output logic              any_next
);
    logic [STAGES-1:0] flags_n;

    always_comb begin
        flags_n  = (flags_q | blk) & ~unblk;
        any_next = |flags_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_n;
    end

    // R2: unblock only on a set flag, never together with block
    assert_unblock_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((unblk & ~flags_q) | (unblk & blk)) == '0);
    // R2: a block pulse leaves the flag set
    assert_block_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|blk) |=> ((flags_q & $past(blk)) == $past(blk)));
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm import fsc_pkg::*; #(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit_sq,
    input  logic            rob_sq,
    input  logic            dec_sq,
    input  logic            stalled,
    input  logic            resp_hit,
    input  logic [ID_W-1:0] resp_id,
    input  logic            grant,
    input  logic [ID_W-1:0] slot_id,
    input  logic            issue_hit,
    input  logic [ID_W-1:0] issue_id,
    input  logic            issue_ok,
    input  logic            cache_blocked,
    output fstat_e          status_o,
    output logic            drop_o,
    output logic            refuse_o,
    output logic            discard_o
);
    fstat_e          st_q, st_n, st_sig;
    logic [ID_W-1:0] oid_q, oid_n;
    logic            discard_n;

    // next-state: signal update, response, retry grant, issue
    always_comb begin
        st_sig    = st_q;
        drop_o    = 1'b0;
        discard_n = 1'b0;
        refuse_o  = 1'b0;
        oid_n     = oid_q;
        if (commit_sq) begin
            st_sig = FS_SQUASH;
            drop_o = 1'b1;
        end else if (rob_sq) begin
            st_sig = FS_SQUASH;
            drop_o = 1'b1;
        end else if (dec_sq && st_q != FS_SQUASH) begin
            st_sig = FS_SQUASH;
            drop_o = 1'b1;
        end else if (stalled && st_q != FS_WAIT_RESP && st_q != FS_WAIT_RETRY) begin
            st_sig = FS_BLOCKED;
        end else if (st_q == FS_BLOCKED || st_q == FS_SQUASH) begin
            st_sig = FS_RUN;
        end

        st_n = st_sig;
        if (resp_hit) begin
            if (st_sig == FS_WAIT_RESP && resp_id == oid_q)
                st_n = stalled ? FS_BLOCKED : FS_ACC_DONE;
            else
                discard_n = 1'b1;
        end

        if (grant && st_n == FS_WAIT_RETRY) begin
            st_n  = FS_WAIT_RESP;
            oid_n = slot_id;
        end

        if (issue_hit && !cache_blocked && (st_n == FS_RUN || st_n == FS_ACC_DONE)) begin
            if (issue_ok) begin
                st_n  = FS_WAIT_RESP;
                oid_n = issue_id;
            end else begin
                st_n     = FS_WAIT_RETRY;
                refuse_o = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= FS_RUN;
            oid_q <= '0;
        end else begin
            st_q  <= st_n;
            oid_q <= oid_n;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) discard_o <= 1'b0;
        else        discard_o <= discard_n;
    end
    assign status_o = st_q;

    assert_commit_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_sq |=> st_q == FS_SQUASH);
    assert_rob_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rob_sq && !commit_sq) |=> st_q == FS_SQUASH);
    assert_wait_ignores_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == FS_WAIT_RESP || st_q == FS_WAIT_RETRY) && stalled && !commit_sq && !rob_sq
         && !dec_sq && !resp_hit && !grant) |=> $stable(st_q));
    assert_stray_resp_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_hit && st_q != FS_WAIT_RESP) |=> discard_o);
endmodule

// File: rtl/fsc_retry_slot.sv
module fsc_retry_slot #(
    parameter int NT    = 2,
    parameter int TID_W = 1,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retry_valid,
    input  logic             resend_ok,
    input  logic [NT-1:0]    drop,
    input  logic [NT-1:0]    refuse,
    input  logic [ID_W-1:0]  refuse_id,
    output logic             slot_v_q,
    output logic [TID_W-1:0] slot_tid_q,
    output logic [ID_W-1:0]  slot_id_q,
    output logic             cb_q,
    output logic [NT-1:0]    grant
);
    logic             live, fire, any_refuse, v_n, cb_n;
    logic [TID_W-1:0] tid_n, refuse_tid;
    logic [ID_W-1:0]  id_n;

    always_comb begin
        refuse_tid = '0;
        for (int t = 0; t < NT; t++)
            if (refuse[t]) refuse_tid = TID_W'(t);
        any_refuse = |refuse;
        live = slot_v_q && !drop[slot_tid_q];
        fire = retry_valid && resend_ok && live;
        grant = '0;
        for (int t = 0; t < NT; t++)
            grant[t] = fire && (slot_tid_q == TID_W'(t));
        v_n   = live && !fire;
        tid_n = slot_tid_q;
        id_n  = slot_id_q;
        cb_n  = cb_q;
        if (retry_valid && (!live || fire)) cb_n = 1'b0;
        if (any_refuse) begin
            v_n   = 1'b1;
            tid_n = refuse_tid;
            id_n  = refuse_id;
            cb_n  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v_q   <= 1'b0;
            slot_tid_q <= '0;
            slot_id_q  <= '0;
            cb_q       <= 1'b0;
        end else begin
            slot_v_q   <= v_n;
            slot_tid_q <= tid_n;
            slot_id_q  <= id_n;
            cb_q       <= cb_n;
        end
    end

    assert_single_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(refuse));
    assert_empty_retry_unblocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_valid && !slot_v_q && !any_refuse) |=> !cb_q);
    assert_grant_frees_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> (!slot_v_q && !cb_q));
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl import fsc_pkg::*; #(
    parameter int NUM_THREADS = 2,
    parameter int ID_W        = 4,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_THREADS-1:0][STAGES-1:0]  stage_block,
    input  logic [NUM_THREADS-1:0][STAGES-1:0]  stage_unblock,
    input  logic                                ctx_stall,
    input  logic [NUM_THREADS-1:0]              commit_squash,
    input  logic [NUM_THREADS-1:0]              rob_squashing,
    input  logic [NUM_THREADS-1:0]              decode_squash,
    input  logic                                issue_valid,
    input  logic [TID_W-1:0]                    issue_tid,
    input  logic [ID_W-1:0]                     issue_id,
    input  logic                                issue_accept,
    input  logic                                resp_valid,
    input  logic [TID_W-1:0]                    resp_tid,
    input  logic [ID_W-1:0]                     resp_id,
    input  logic                                retry_valid,
    input  logic                                retry_resend_ok,
    output logic [NUM_THREADS-1:0][3:0]         thread_status,
    output logic                                retry_pending,
    output logic [TID_W-1:0]                    retry_tid,
    output logic                                cache_blocked,
    output logic                                resp_discard
);
    logic [NUM_THREADS-1:0] drop, refuse, grant, discard;
    logic [ID_W-1:0]        slot_id;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic [STAGES-1:0] flags_q;
        logic              any_next;
        fstat_e            st;

        fsc_stall_flags u_flags (
            .clk      (clk),
            .rst_n    (rst_n),
            .blk      (stage_block[t]),
            .unblk    (stage_unblock[t]),
            .flags_q  (flags_q),
            .any_next (any_next)
        );

        fsc_thread_fsm #(.ID_W(ID_W)) u_fsm (
            .clk           (clk),
            .rst_n         (rst_n),
            .commit_sq     (commit_squash[t]),
            .rob_sq        (rob_squashing[t]),
            .dec_sq        (decode_squash[t]),
            .stalled       (any_next | ctx_stall),
            .resp_hit      (resp_valid && resp_tid == TID_W'(t)),
            .resp_id       (resp_id),
            .grant         (grant[t]),
            .slot_id       (slot_id),
            .issue_hit     (issue_valid && issue_tid == TID_W'(t)),
            .issue_id      (issue_id),
            .issue_ok      (issue_accept),
            .cache_blocked (cache_blocked),
            .status_o      (st),
            .drop_o        (drop[t]),
            .refuse_o      (refuse[t]),
            .discard_o     (discard[t])
        );

        assign thread_status[t] = st;

        assert_blocked_by_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (|flags_q && st != FS_WAIT_RESP && st != FS_WAIT_RETRY) |-> st != FS_RUN);
    end

    fsc_retry_slot #(.NT(NUM_THREADS), .TID_W(TID_W), .ID_W(ID_W)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .retry_valid (retry_valid),
        .resend_ok   (retry_resend_ok),
        .drop        (drop),
        .refuse      (refuse),
        .refuse_id   (issue_id),
        .slot_v_q    (retry_pending),
        .slot_tid_q  (retry_tid),
        .slot_id_q   (slot_id),
        .cb_q        (cache_blocked),
        .grant       (grant)
    );

    assign resp_discard = |discard;

    // R13: slot owner sits in WaitRetry
    assert_slot_owner_waits_R13: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pending |-> fstat_e'(thread_status[retry_tid]) == FS_WAIT_RETRY);
    assert_pending_means_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pending |-> cache_blocked);
endmodule

// File: tb/test_fetch_status_ctrl.sv
module test_fetch_status_ctrl;
    localparam int NT = 2;
    localparam int S_RUN = 0, S_SQ = 2, S_BLK = 3, S_WRESP = 6, S_WRETRY = 7, S_DONE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0][3:0] stage_block, stage_unblock;
    logic ctx_stall;
    logic [NT-1:0] commit_squash, rob_squashing, decode_squash;
    logic issue_valid, issue_accept, resp_valid, retry_valid, retry_resend_ok;
    logic [0:0] issue_tid, resp_tid, retry_tid;
    logic [3:0] issue_id, resp_id;
    logic [NT-1:0][3:0] thread_status;
    logic retry_pending, cache_blocked, resp_discard;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    fetch_status_ctrl #(.NUM_THREADS(NT), .ID_W(4)) i_fetch_status_ctrl (
        .clk(clk), .rst_n(rst_n),
        .stage_block(stage_block), .stage_unblock(stage_unblock),
        .ctx_stall(ctx_stall), .commit_squash(commit_squash),
        .rob_squashing(rob_squashing), .decode_squash(decode_squash),
        .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_id(issue_id),
        .issue_accept(issue_accept), .resp_valid(resp_valid), .resp_tid(resp_tid),
        .resp_id(resp_id), .retry_valid(retry_valid), .retry_resend_ok(retry_resend_ok),
        .thread_status(thread_status), .retry_pending(retry_pending),
        .retry_tid(retry_tid), .cache_blocked(cache_blocked), .resp_discard(resp_discard)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        stage_block = '0; stage_unblock = '0; ctx_stall = 0;
        commit_squash = '0; rob_squashing = '0; decode_squash = '0;
        issue_valid = 0; issue_accept = 0; issue_tid = '0; issue_id = '0;
        resp_valid = 0; resp_tid = '0; resp_id = '0;
        retry_valid = 0; retry_resend_ok = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        clr();
    endtask

    task automatic issue(input int t, input int id, input bit ok);
        issue_valid = 1; issue_tid = 1'(t); issue_id = 4'(id); issue_accept = ok;
    endtask

    task automatic resp(input int t, input int id);
        resp_valid = 1; resp_tid = 1'(t); resp_id = 4'(id);
    endtask

    function automatic int model(input int s, input bit c, input bit r, input bit d, input bit st);
        if (c) return S_SQ;
        if (r) return S_SQ;
        if (d && s != S_SQ) return S_SQ;
        if (st && s != S_WRESP && s != S_WRETRY) return S_BLK;
        if (s == S_BLK || s == S_SQ) return S_RUN;
        return s;
    endfunction

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clr();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 t0", thread_status[0], S_RUN);
        chk("R1 t1", thread_status[1], S_RUN);
        chk("R1 pending", retry_pending, 0);
        chk("R1 cblk", cache_blocked, 0);

        // R2 sticky flags per stage
        for (int s = 0; s < 4; s++) begin
            stage_block[1][s] = 1'b1; tick();
            chk("R2 block", thread_status[1], S_BLK);
            chk("R2 other", thread_status[0], S_RUN);
            tick();
            chk("R2 sticky", thread_status[1], S_BLK);
            stage_unblock[1][s] = 1'b1; tick();
            chk("R2 unblock", thread_status[1], S_RUN);
        end

        // R3 R4 R5 R6 R8 priority sweep
        for (int s0 = 0; s0 < 3; s0++) begin
            for (int k = 0; k < 16; k++) begin
                int start;
                start = (s0 == 0) ? S_RUN : (s0 == 1) ? S_SQ : S_BLK;
                if (start == S_SQ) begin commit_squash[0] = 1; tick(); end
                if (start == S_BLK) begin ctx_stall = 1; tick(); end
                commit_squash[0] = k[3]; rob_squashing[0] = k[2];
                decode_squash[0] = k[1]; ctx_stall = k[0];
                tick();
                chk("R3/R4/R5/R6/R8 sweep", thread_status[0],
                    model(start, k[3], k[2], k[1], k[0]));
                tick(); tick();
            end
        end

        // R9 accept, R7 stall ignored, R10 response filtering
        issue(0, 5, 1); tick();
        chk("R9 accept", thread_status[0], S_WRESP);
        ctx_stall = 1; tick();
        chk("R7 wait keeps", thread_status[0], S_WRESP);
        resp(0, 3); tick();
        chk("R10 wrong id status", thread_status[0], S_WRESP);
        chk("R10 wrong id discard", resp_discard, 1);
        ctx_stall = 1; resp(0, 5); tick();
        chk("R10 stalled done", thread_status[0], S_BLK);
        chk("R10 no discard", resp_discard, 0);
        tick();
        chk("R8 back", thread_status[0], S_RUN);
        issue(0, 7, 1); tick();
        resp(0, 7); tick();
        chk("R10 done", thread_status[0], S_DONE);
        resp(0, 7); tick();
        chk("R10 stray discard", resp_discard, 1);
        chk("R10 stray status", thread_status[0], S_DONE);

        // R9 refuse, ignore while blocked; R11 retry
        issue(1, 9, 0); tick();
        chk("R9 refuse status", thread_status[1], S_WRETRY);
        chk("R9 pending", retry_pending, 1);
        chk("R9 tid", retry_tid, 1);
        chk("R9 cblk", cache_blocked, 1);
        issue(0, 1, 1); tick();
        chk("R9 ignored", thread_status[0], S_DONE);
        retry_valid = 1; retry_resend_ok = 0; tick();
        chk("R11 fail keeps", thread_status[1], S_WRETRY);
        chk("R11 fail pending", retry_pending, 1);
        retry_valid = 1; retry_resend_ok = 1; tick();
        chk("R11 grant", thread_status[1], S_WRESP);
        chk("R11 slot free", retry_pending, 0);
        chk("R11 unblocked", cache_blocked, 0);
        resp(1, 9); tick();
        chk("R11 resp after retry", thread_status[1], S_DONE);

        // R4 R12 squash empties slot, later retry only unblocks
        issue(0, 2, 0); tick();
        chk("R9 refuse t0", thread_status[0], S_WRETRY);
        commit_squash[1] = 1; tick();
        chk("R4 other thread keeps slot", retry_pending, 1);
        tick();
        commit_squash[0] = 1; tick();
        chk("R4 squash", thread_status[0], S_SQ);
        chk("R4 slot cleared", retry_pending, 0);
        chk("R12 still blocked", cache_blocked, 1);
        retry_valid = 1; retry_resend_ok = 1; tick();
        chk("R12 unblock", cache_blocked, 0);
        chk("R12 no owner", retry_pending, 0);
        chk("R12 t0 status", thread_status[0], S_RUN);

        // R4 collision: squash with matching response
        issue(0, 4, 1); tick();
        commit_squash[0] = 1; resp(0, 4); tick();
        chk("R4 collide status", thread_status[0], S_SQ);
        chk("R4 collide discard", resp_discard, 1);
        resp(0, 4); tick();
        chk("R4 dropped request", resp_discard, 1);
        chk("R8 recovered", thread_status[0], S_RUN);

        // R6 decode squash on waiting thread
        issue(0, 6, 1); tick();
        decode_squash[0] = 1; tick();
        chk("R6 squash", thread_status[0], S_SQ);
        decode_squash[0] = 1; tick();
        chk("R6 already squashing", thread_status[0], S_RUN);

        // R5 R12 collision: ROB squash and successful retry together
        issue(1, 11, 0); tick();
        rob_squashing[1] = 1; retry_valid = 1; retry_resend_ok = 1; tick();
        chk("R5 squash", thread_status[1], S_SQ);
        chk("R5 slot cleared", retry_pending, 0);
        chk("R12 collide unblock", cache_blocked, 0);
        chk("R13 other thread", thread_status[0], S_RUN);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule